// File: doc/BRIEF.md
# Staged Multichannel DAC Frame Controller

This block sits between a write port driven by software and a converter link that sends one frame of output codes at a fixed interval. It holds a bank of staged 16-bit codes, one per channel. For each outgoing frame it decides which staged codes replace the values the converters currently hold. Codes are offset binary: 0x8000 is the mid-scale (zero volt) code.

A write names a channel address and carries one code, or an aligned power-of-two group of codes. A write only stages data. Channels whose hold bit is clear pick up new data at the next frame edge. Channels whose hold bit is set keep new data back until software raises their update bit. Update bits clear themselves when the frame carrying them goes out. This lets many channels change together at a single frame edge.

Top module: `dac_frame_stager`

## Requirements
- R1: A write changes only the staged code. `frame_codes` changes only in a cycle where `frame_strobe` is high.
- R2: A channel whose hold bit is clear and that has newly staged data shows the staged code in `frame_codes` at the next frame strobe.
- R3: A channel whose hold bit is set keeps its old output code across frames, until its update bit is set. Its staged code then appears at the next frame strobe.
- R4: All update bits clear at each frame edge. After that, held channels release nothing until their update bits are set again. An update request written in the frame-edge cycle is kept for the following frame.
- R5: A write carries 2^LOG2_GRP codes. Code k sits at `wr_data` bits [16k+15:16k] and fills channel `wr_addr + k`.
- R6: `frame_strobe` is high for exactly one cycle in every FRAME_CYCLES cycles. The first strobe comes FRAME_CYCLES cycles after reset is released.
- R7: A write in the cycle before a frame strobe (the frame-edge cycle) does not change the frame being emitted. It goes out at the following frame.
- R8: A write whose address has any of its low LOG2_GRP bits set changes no staged code. It sets `align_err`, which stays set until reset.
- R9: After reset, every output code and every staged code is 0x8000. The hold mask and the update requests are zero, `align_err` is 0 and `frame_changed` is 0.
- R10: `frame_changed[i]` is high only together with `frame_strobe`. It is high exactly when channel i was released in that frame with a code different from the code it held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Stage the codes on `wr_data` |
| wr_addr | input | 5 | First channel of the written group |
| wr_data | input | 16·2^LOG2_GRP | Packed codes, lowest channel in the lowest bits |
| hold_wr | input | 1 | Load the hold mask from `hold_in` |
| hold_in | input | 32 | New hold mask, one bit per channel |
| upd_wr | input | 1 | OR `upd_in` into the update requests |
| upd_in | input | 32 | Update request bits, one per channel |
| frame_strobe | output | 1 | One-cycle marker of a new frame |
| frame_codes | output | 512 | Codes in force, channel i at bits [16i+15:16i] |
| frame_changed | output | 32 | Per-channel flag: code changed in this frame |
| align_err | output | 1 | Sticky flag for a misaligned group write |

## Verification
The bench targets the following corner cases:
- A write in the frame-edge cycle. A design that got this wrong would leak the code into the frame already leaving.
- A held channel after its update has been consumed. A design that does not clear update bits would keep releasing every later write.
- A misaligned group address. A design that got this wrong would corrupt neighbouring channels or let the error flag drop.
- Rewriting the same code. A design that got this wrong would still flag a change.

A behavioural model of staging, hold and release runs alongside. It is compared with every output on every cycle, under directed and random traffic.

// File: rtl/dfs_pkg.sv
// Package: shared constants for the staged DAC frame controller.
// Assumes offset-binary codes whose mid-scale value has only the top bit set.
package dfs_pkg;
    localparam int DFS_CODE_W = 16;

    // Mid-scale (zero volt) code for a given code width.
    function automatic logic [DFS_CODE_W-1:0] dfs_mid_code();
        return DFS_CODE_W'(1) << (DFS_CODE_W - 1);
    endfunction
endpackage

// File: rtl/dfs_frame_timer.sv
// Module: free-running frame timer. It raises tick in the last cycle of each
// frame period. Assumes FRAME_CYCLES >= 2.
module dfs_frame_timer #(
    parameter int FRAME_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count cycles within the frame and wrap at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/dfs_stage_bank.sv
// Module: bank of staged codes with per-channel dirty bits. An aligned write
// fills a group of 2^LOG2_GRP channels. A misaligned write is dropped and sets
// a sticky error flag. Dirty bits of released channels clear at the frame
// edge; a write in that same cycle wins.
module dfs_stage_bank
    import dfs_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int CODE_W   = DFS_CODE_W,
    parameter int LOG2_GRP = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [$clog2(NCH)-1:0]           wr_addr,
    input  logic [CODE_W*(1<<LOG2_GRP)-1:0]  wr_data,
    input  logic                             tick,
    input  logic [NCH-1:0]                   release_vec,
    output logic [NCH*CODE_W-1:0]            staged_flat,
    output logic [NCH-1:0]                   dirty,
    output logic                             align_err
);
    localparam int ADDR_W = $clog2(NCH);
    localparam int GRP    = 1 << LOG2_GRP;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(GRP - 1);

    logic misaligned;
    logic wr_ok;

    assign misaligned = (wr_addr & LOW_MASK) != '0;
    assign wr_ok      = wr_en && !misaligned;

    // Latch the misalignment error until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  align_err <= 1'b0;
        else if (wr_en && misaligned) align_err <= 1'b1;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit = wr_ok && ((wr_addr >> LOG2_GRP) == ADDR_W'(ch >> LOG2_GRP));

        // Hold this channel's staged code and its pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                staged_flat[ch*CODE_W +: CODE_W] <= dfs_mid_code();
                dirty[ch] <= 1'b0;
            end else if (hit) begin
                staged_flat[ch*CODE_W +: CODE_W] <= wr_data[(ch % GRP)*CODE_W +: CODE_W];
                dirty[ch] <= 1'b1;
            end else if (tick && release_vec[ch]) begin
                dirty[ch] <= 1'b0;
            end
        end
    end

    assert_misaligned_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && misaligned) |=> $stable(staged_flat));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);
endmodule

// File: rtl/dfs_release_ctrl.sv
// Module: hold mask and self-clearing update requests. It decides which dirty
// channels go out at the next frame edge. Update requests written in the
// frame-edge cycle survive into the next frame.
module dfs_release_ctrl #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           hold_wr,
    input  logic [NCH-1:0] hold_in,
    input  logic           upd_wr,
    input  logic [NCH-1:0] upd_in,
    input  logic [NCH-1:0] dirty,
    output logic [NCH-1:0] release_vec
);
    logic [NCH-1:0] hold_q;
    logic [NCH-1:0] upd_q;
    logic [NCH-1:0] upd_keep;

    assign release_vec = dirty & (~hold_q | upd_q);
    assign upd_keep    = tick ? '0 : upd_q;

    // Load the hold mask on request.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (hold_wr) hold_q <= hold_in;
    end

    // Accumulate update requests; drop them once a frame has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= '0;
        else        upd_q <= upd_keep | (upd_wr ? upd_in : '0);
    end

    assert_upd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !upd_wr) |=> (upd_q == '0));
    assert_held_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q == '0) |-> ((release_vec & hold_q) == '0));
endmodule

// File: rtl/dac_frame_stager.sv
// Module: top of the staged DAC frame controller. At each frame edge it copies
// released staged codes into the output register, and flags the channels
// whose code actually changed. Assumes FRAME_CYCLES >= 2 and 0 <= LOG2_GRP <= 5.
module dac_frame_stager
    import dfs_pkg::*;
#(
    parameter int NCH          = 32,
    parameter int CODE_W       = DFS_CODE_W,
    parameter int LOG2_GRP     = 2,
    parameter int FRAME_CYCLES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(NCH)-1:0]          wr_addr,
    input  logic [CODE_W*(1<<LOG2_GRP)-1:0] wr_data,
    input  logic                            hold_wr,
    input  logic [NCH-1:0]                  hold_in,
    input  logic                            upd_wr,
    input  logic [NCH-1:0]                  upd_in,
    output logic                            frame_strobe,
    output logic [NCH*CODE_W-1:0]           frame_codes,
    output logic [NCH-1:0]                  frame_changed,
    output logic                            align_err
);
    logic                   tick;
    logic [NCH*CODE_W-1:0]  staged_flat;
    logic [NCH-1:0]         dirty;
    logic [NCH-1:0]         release_vec;
    logic                   past_ok;

    dfs_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    dfs_stage_bank #(.NCH(NCH), .CODE_W(CODE_W), .LOG2_GRP(LOG2_GRP)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .release_vec(release_vec),
        .staged_flat(staged_flat), .dirty(dirty), .align_err(align_err));

    dfs_release_ctrl #(.NCH(NCH)) rel_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold_wr(hold_wr),
        .hold_in(hold_in), .upd_wr(upd_wr), .upd_in(upd_in),
        .dirty(dirty), .release_vec(release_vec));

    // Emit the frame marker one cycle after the timer tick.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_strobe <= 1'b0;
        else        frame_strobe <= tick;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
        logic [CODE_W-1:0] stg;
        logic [CODE_W-1:0] cur;
        assign stg = staged_flat[ch*CODE_W +: CODE_W];
        assign cur = frame_codes[ch*CODE_W +: CODE_W];

        // Update this channel's output code and change flag at the frame edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_codes[ch*CODE_W +: CODE_W] <= dfs_mid_code();
                frame_changed[ch] <= 1'b0;
            end else if (tick && release_vec[ch]) begin
                frame_codes[ch*CODE_W +: CODE_W] <= stg;
                frame_changed[ch] <= (stg != cur);
            end else begin
                frame_changed[ch] <= 1'b0;
            end
        end
    end

    // Mark the first cycle that has a valid previous sample after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_codes_frame_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !frame_strobe) |-> $stable(frame_codes));
    assert_changed_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_changed != '0) |-> frame_strobe);
endmodule

// File: tb/dac_frame_stager_tb_top.sv
module dac_frame_stager_tb_top;
    localparam int NCH = 32;
    localparam int CW  = 16;
    localparam int LG  = 2;
    localparam int GRP = 1 << LG;
    localparam int FC  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [CW*GRP-1:0] wr_data = '0;
    logic hold_wr = 1'b0;
    logic [NCH-1:0] hold_in = '0;
    logic upd_wr = 1'b0;
    logic [NCH-1:0] upd_in = '0;
    logic frame_strobe;
    logic [NCH*CW-1:0] frame_codes;
    logic [NCH-1:0] frame_changed;
    logic align_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dac_frame_stager #(.NCH(NCH), .CODE_W(CW), .LOG2_GRP(LG), .FRAME_CYCLES(FC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hold_wr(hold_wr), .hold_in(hold_in), .upd_wr(upd_wr), .upd_in(upd_in),
        .frame_strobe(frame_strobe), .frame_codes(frame_codes),
        .frame_changed(frame_changed), .align_err(align_err));

    // Behavioural reference model state
    int m_cnt;
    int m_staged[NCH];
    bit m_dirty[NCH];
    bit m_hold[NCH];
    bit m_upd[NCH];
    int m_out[NCH];
    bit m_chg[NCH];
    bit m_strobe;
    bit m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_strobe = 0; m_err = 0;
            foreach (m_out[i]) begin
                m_staged[i] = 'h8000; m_out[i] = 'h8000;
                m_dirty[i] = 0; m_hold[i] = 0; m_upd[i] = 0; m_chg[i] = 0;
            end
        end else begin
            bit t;
            t = (m_cnt == FC - 1);
            m_cnt = t ? 0 : m_cnt + 1;
            m_strobe = t;
            foreach (m_out[i]) begin
                m_chg[i] = 0;
                if (t && m_dirty[i] && (!m_hold[i] || m_upd[i])) begin
                    m_chg[i] = (m_staged[i] != m_out[i]);
                    m_out[i] = m_staged[i];
                    m_dirty[i] = 0;
                end
                if (t) m_upd[i] = 0;
            end
            if (upd_wr) foreach (m_upd[i]) if (upd_in[i]) m_upd[i] = 1;
            if (hold_wr) foreach (m_hold[i]) m_hold[i] = hold_in[i];
            if (wr_en) begin
                if (wr_addr % GRP != 0) m_err = 1;
                else for (int k = 0; k < GRP; k++) begin
                    m_staged[wr_addr + k] = int'(wr_data[k*CW +: CW]);
                    m_dirty[wr_addr + k] = 1;
                end
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int code_of(int ch);
        return int'(frame_codes[ch*CW +: CW]);
    endfunction

    // Full comparison against the model on every cycle (away from the edge).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(frame_strobe == m_strobe, "R6 strobe", frame_strobe, m_strobe);
            check(align_err == m_err, "R8 align_err", align_err, m_err);
            for (int i = 0; i < NCH; i++) begin
                if (code_of(i) != m_out[i])
                    check(0, $sformatf("R2/R3 code ch%0d", i), code_of(i), m_out[i]);
                if (frame_changed[i] != m_chg[i])
                    check(0, $sformatf("R10 changed ch%0d", i), frame_changed[i], m_chg[i]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(int addr, logic [CW*GRP-1:0] d);
        wr_en = 1; wr_addr = 5'(addr); wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic phase(int p);
        do @(negedge clk); while (m_cnt != p);
    endtask

    task automatic next_strobe();
        do @(negedge clk); while (!frame_strobe);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check(code_of(5) == 'h8000, "R9 reset code", code_of(5), 'h8000);
        check(align_err == 0, "R9 reset err", align_err, 0);
        check(frame_changed == '0, "R9 reset changed", frame_changed, 0);

        // R5 group write, R1 staging only, R2 next frame
        phase(2);
        wr(0, {16'h4444, 16'h3333, 16'h2222, 16'h1111});
        check(code_of(1) == 'h8000, "R1 staged only", code_of(1), 'h8000);
        next_strobe();
        check(code_of(0) == 'h1111, "R5 group ch0", code_of(0), 'h1111);
        check(code_of(3) == 'h4444, "R5 group ch3", code_of(3), 'h4444);
        check(frame_changed[2] == 1, "R10 changed set", frame_changed[2], 1);

        // R3 held channels wait for update
        hold_wr = 1; hold_in = 32'h0000_00F0; @(negedge clk); hold_wr = 0;
        phase(3);
        wr(4, {16'hA003, 16'hA002, 16'hA001, 16'hA000});
        next_strobe(); next_strobe();
        check(code_of(4) == 'h8000, "R3 held stays", code_of(4), 'h8000);
        upd_wr = 1; upd_in = 32'h0000_00F0; @(negedge clk); upd_wr = 0;
        next_strobe();
        check(code_of(4) == 'hA000, "R3 update releases", code_of(4), 'hA000);
        check(code_of(7) == 'hA003, "R3 update releases ch7", code_of(7), 'hA003);

        // R4 update bits self-clear
        phase(4);
        wr(4, {16'hB003, 16'hB002, 16'hB001, 16'hB000});
        next_strobe(); next_strobe();
        check(code_of(5) == 'hA001, "R4 update consumed", code_of(5), 'hA001);
        // R4 update written at the edge survives
        phase(FC - 1);
        upd_wr = 1; upd_in = 32'h0000_0010; @(negedge clk); upd_wr = 0;
        check(code_of(4) == 'hA000, "R4 edge update waits", code_of(4), 'hA000);
        next_strobe();
        check(code_of(4) == 'hB000, "R4 edge update next", code_of(4), 'hB000);

        // R7 write in frame-edge cycle goes to the following frame
        phase(FC - 1);
        wr(8, {16'h0C03, 16'h0C02, 16'h0C01, 16'h0C00});
        check(frame_strobe == 1, "R7 strobe present", frame_strobe, 1);
        check(code_of(8) == 'h8000, "R7 not in this frame", code_of(8), 'h8000);
        next_strobe();
        check(code_of(8) == 'h0C00, "R7 following frame", code_of(8), 'h0C00);

        // R8 misaligned write ignored, error sticky
        phase(5);
        wr(9, {16'hDEAD, 16'hDEAD, 16'hDEAD, 16'hDEAD});
        check(align_err == 1, "R8 err set", align_err, 1);
        next_strobe();
        check(code_of(9) == 'h0C01, "R8 ignored", code_of(9), 'h0C01);
        check(code_of(10) == 'h0C02, "R8 ignored ch10", code_of(10), 'h0C02);
        check(align_err == 1, "R8 err sticky", align_err, 1);

        // R10 same code rewrite: released but not changed
        phase(6);
        wr(8, {16'h0C03, 16'h0C02, 16'h0C01, 16'h0C00});
        next_strobe();
        check(frame_changed[8] == 0, "R10 same code", frame_changed[8], 0);

        // Random traffic compared against the model each cycle
        for (int n = 0; n < 600; n++) begin
            wr_en = ($urandom_range(0, 2) == 0);
            wr_addr = 5'($urandom_range(0, 31) & (($urandom_range(0, 9) == 0) ? 31 : 28));
            wr_data = {$urandom, $urandom};
            hold_wr = ($urandom_range(0, 40) == 0);
            hold_in = $urandom;
            upd_wr = ($urandom_range(0, 10) == 0);
            upd_in = $urandom;
            @(negedge clk);
        end
        wr_en = 0; hold_wr = 0; upd_wr = 0;
        repeat (2 * FC) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule